// File: doc/BRIEF.md
# Bus-Driven Test Clock-Enable Controller

This block sits on an APB slave port next to a peripheral and owns the single clock-enable that every flip-flop of that peripheral uses. In normal operation the enable is held high, so the peripheral advances on every clock. Test software can switch it to one of two stepping modes. In the first, every bus transfer advances the peripheral by exactly one clock. In the second, only transfers that fall inside a dedicated address window advance it. That window holds no storage: reads of it return zero and writes to it are thrown away. It spans sixteen words, so a burst of accesses gives a run of enable pulses.

The same 5-bit control register also drives a soft reset for the peripheral. The controller's own registers are not affected by that reset. A fifth bit switches the peripheral's primary input from the external pin to a one-bit stimulus register, so the receive path can be driven from software.

Top module: `tce_top`

## Requirements
- R1: After a synchronous reset the control and stimulus registers read 0, `clk_en` is 1, `soft_rst` is 0 and `prim_in` follows `ext_in`.
- R2: Unless control bits 0 and 1 are both 1, `clk_en` is 1 in every cycle. Bit 1 alone, bit 2 alone, or bits 0 and 2 together, leave it at 1.
- R3: In strobe mode (control bits 0 and 1 set, bit 2 clear), `clk_en` is 1 exactly in the access-phase cycle of each transfer (`psel` and `penable` both 1). This holds for a read or a write, at any address, and `clk_en` is 0 in all other cycles.
- R4: In window mode (control bits 0, 1 and 2 set), `clk_en` is 1 only in the access phase of a transfer whose address lies in 0x40..0x7F, and is 0 otherwise.
- R5: A read from any address in 0x40..0x7F returns 0. A write there leaves the control and stimulus registers unchanged.
- R6: Control bit 3 drives `soft_rst` from the cycle after the write that sets it. The control and stimulus registers keep their values and still read back while it is high.
- R7: When control bit 4 is 1, `prim_in` equals bit 0 of the stimulus register. When bit 4 is 0, `prim_in` equals `ext_in`.
- R8: The control register is at 0x80, with its fields in bits 4:0. The stimulus register is at 0x88, in bit 0. Bits 31:5 of 0x80 and bits 31:1 of 0x88 read 0, and writes to them are ignored. Any other address, and `prdata` outside a read transfer, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid while a read is selected |
| ext_in | input | 1 | Primary input from the external pin |
| clk_en | output | 1 | Clock-enable for the peripheral's flip-flops |
| soft_rst | output | 1 | Reset for the peripheral from control bit 3 |
| prim_in | output | 1 | Selected primary input for the peripheral |

## Verification
A wrong bit in the control register shows at `clk_en` in the very next cycle: idle cycles start dropping the enable, or the enable appears where it should not. The same fault shows on the next read of 0x80. A stimulus or select bit that is wrong appears on `prim_in` one cycle after the write. A window decode that is wrong shows in the access phase of the offending transfer, either as a missing or extra pulse or as nonzero read data. The bench therefore compares every output against a behavioural model on every clock, so each such fault is caught in the cycle where it first becomes visible.

// File: rtl/tce_pkg.sv
package tce_pkg;
  localparam int CTRL_W = 5;
  localparam int STIM_W = 1;

  // Field order: the LSB of the packed struct is control bit 0.
  typedef struct packed {
    logic in_sel;   // bit 4: primary input from stimulus register
    logic srst;     // bit 3: peripheral soft reset
    logic win_mode; // bit 2: enable only on window hits
    logic step;     // bit 1: stepped clock-enable
    logic test;     // bit 0: test mode
  } ctrl_t;
endpackage

// File: rtl/tce_decode.sv
module tce_decode #(
  parameter int ADDR_W    = 12,
  parameter int CTRL_OFF  = 'h80,
  parameter int STIM_OFF  = 'h88,
  parameter int WIN_BASE  = 'h40,
  parameter int WIN_WORDS = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ctrl,
  output logic              hit_stim,
  output logic              hit_win
);
  localparam int WIN_BYTES = WIN_WORDS * 4;
  localparam int WIN_END   = WIN_BASE + WIN_BYTES - 1;
  localparam bit WIN_POW2  = ((WIN_BYTES & (WIN_BYTES - 1)) == 0) &&
                             ((WIN_BASE % WIN_BYTES) == 0);
  localparam int SH        = $clog2(WIN_BYTES);

  logic [ADDR_W-3:0] word;
  assign word     = addr[ADDR_W-1:2];
  assign hit_ctrl = (word == ADDR_W'(CTRL_OFF) >> 2) ? 1'b1 : 1'b0;
  assign hit_stim = (word == ADDR_W'(STIM_OFF) >> 2) ? 1'b1 : 1'b0;

  generate
    if (WIN_POW2) begin : g_mask
      assign hit_win = ((addr >> SH) == (ADDR_W'(WIN_BASE) >> SH));
    end else begin : g_range
      assign hit_win = (addr >= ADDR_W'(WIN_BASE)) && (addr <= ADDR_W'(WIN_END));
    end
  endgenerate
endmodule

// File: rtl/tce_regs.sv
module tce_regs
  import tce_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_stim,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output logic              stim_q
);
  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      stim_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_stim) stim_q <= wdata[0];
    end
  end

  AST_STIM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_stim |=> $stable(stim_q)) else $error("stim changed without write"); // R8
endmodule

// File: rtl/tce_clken.sv
module tce_clken (
  input  logic clk,
  input  logic rst,
  input  logic test,
  input  logic step,
  input  logic win_mode,
  input  logic psel,
  input  logic penable,
  input  logic hit_win,
  output logic clk_en
);
  logic access;
  logic stepping;
  assign access   = psel & penable;
  assign stepping = test & step;

  always_comb begin
    if (!stepping)     clk_en = 1'b1;
    else if (win_mode) clk_en = access & hit_win;
    else               clk_en = access;
  end

  AST_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
    !(test && step) |-> clk_en) else $error("enable dropped in normal mode"); // R2
  AST_PULSE_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (test && step && clk_en) |-> (psel && penable)) else $error("pulse outside access"); // R3
  AST_WIN_ONLY: assert property (@(posedge clk) disable iff (rst)
    (test && step && win_mode && clk_en) |-> hit_win) else $error("pulse off window"); // R4
endmodule

// File: rtl/tce_top.sv
module tce_top
  import tce_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int CTRL_OFF  = 'h80,
  parameter int STIM_OFF  = 'h88,
  parameter int WIN_BASE  = 'h40,
  parameter int WIN_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              ext_in,
  output logic              clk_en,
  output logic              soft_rst,
  output logic              prim_in
);
  logic  hit_ctrl, hit_stim, hit_win;
  logic  wr_go;
  ctrl_t ctrl_q;
  logic  stim_q;

  tce_decode #(
    .ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .STIM_OFF(STIM_OFF),
    .WIN_BASE(WIN_BASE), .WIN_WORDS(WIN_WORDS)
  ) u_dec (
    .addr(paddr), .hit_ctrl(hit_ctrl), .hit_stim(hit_stim), .hit_win(hit_win)
  );

  assign wr_go = psel & penable & pwrite;

  tce_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_ctrl(wr_go & hit_ctrl), .wr_stim(wr_go & hit_stim),
    .wdata(pwdata), .ctrl_q(ctrl_q), .stim_q(stim_q)
  );

  tce_clken u_en (
    .clk(clk), .rst(rst),
    .test(ctrl_q.test), .step(ctrl_q.step), .win_mode(ctrl_q.win_mode),
    .psel(psel), .penable(penable), .hit_win(hit_win), .clk_en(clk_en)
  );

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (hit_ctrl)      prdata[CTRL_W-1:0] = ctrl_q;
      else if (hit_stim) prdata[0]          = stim_q;
    end
  end

  assign soft_rst = ctrl_q.srst;
  assign prim_in  = ctrl_q.in_sel ? stim_q : ext_in;

  AST_WIN_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (psel && !pwrite && hit_win) |-> (prdata == '0)) else $error("window read nonzero"); // R5
  AST_WIN_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_go && hit_win) |=> ($stable(ctrl_q) && $stable(stim_q))) else $error("window write stored"); // R5
  AST_SRST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (wr_go && hit_ctrl) |=> (soft_rst == $past(pwdata[3]))) else $error("soft reset mismatch"); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (psel && !pwrite) |-> (prdata[DATA_W-1:CTRL_W] == '0)) else $error("reserved bits nonzero"); // R8
endmodule

// File: tb/sim_tce_top.sv
module sim_tce_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        ext_in = 1'b0;
  logic        clk_en, soft_rst, prim_in;

  int  total = 0;
  int  fails = 0;
  bit  armed = 1'b0;
  bit  done  = 1'b0;
  int  ctrl_m = 0;
  int  stim_m = 0;

  always #4 clk = ~clk;

  tce_top u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_in(ext_in),
    .clk_en(clk_en), .soft_rst(soft_rst), .prim_in(prim_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Reference state, updated at the same edge the design samples a write.
  always @(posedge clk) begin
    if (rst) begin
      ctrl_m = 0;
      stim_m = 0;
      armed  = 1'b1;
    end else if (psel && penable && pwrite) begin
      if (paddr == 12'h080) ctrl_m = pwdata & 32'h1f;
      if (paddr == 12'h088) stim_m = pwdata & 32'h1;
    end
  end

  // Per-cycle comparison, mid-cycle.
  always @(negedge clk) begin
    if (armed && !done) begin
      bit tm, acc, inwin, e_en;
      logic [31:0] e_rd;
      string t_en, t_rd;
      tm    = ctrl_m[0] && ctrl_m[1];
      acc   = psel && penable;
      inwin = (paddr >= 12'h040) && (paddr <= 12'h07f);
      if (!tm)           begin e_en = 1'b1;        t_en = "R2"; end
      else if (ctrl_m[2]) begin e_en = acc && inwin; t_en = "R4"; end
      else               begin e_en = acc;         t_en = "R3"; end
      e_rd = '0;
      if (psel && !pwrite) begin
        if (paddr == 12'h080) e_rd = ctrl_m;
        if (paddr == 12'h088) e_rd = stim_m;
      end
      t_rd = (psel && !pwrite && inwin) ? "R5" : "R8";
      if (rst) begin t_en = "R1"; t_rd = "R1"; end
      check(t_en, {31'b0, clk_en}, {31'b0, e_en});
      check(t_rd, prdata, e_rd);
      check(rst ? "R1" : "R6", {31'b0, soft_rst}, {31'b0, ctrl_m[3]});
      check(rst ? "R1" : "R7", {31'b0, prim_in},
            {31'b0, (ctrl_m[4] ? stim_m[0] : ext_in)});
    end
  end

  task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pwdata = '0;
  endtask

  task automatic summary;
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      ext_in = $urandom_range(0, 1);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", {31'b0, clk_en}, 32'd1);
    check("R1", {31'b0, soft_rst}, 32'd0);
    check("R1", {31'b0, prim_in}, {31'b0, ext_in});
    apb(0, 12'h080, 0);                 // R1 control reads 0
    apb(0, 12'h088, 0);                 // R1 stimulus reads 0
    apb(1, 12'h080, 32'h2);             // R2 bit 1 alone
    apb(0, 12'h010, 0);
    apb(1, 12'h080, 32'h5);             // R2 bits 0 and 2 only
    apb(1, 12'h044, 0);
    apb(1, 12'h080, 32'h3);             // R3 strobe mode
    apb(0, 12'h010, 0);
    apb(1, 12'h084, 32'h1234);
    apb(0, 12'h040, 0);
    repeat (3) @(posedge clk);
    apb(1, 12'h080, 32'h7);             // R4 window mode
    apb(0, 12'h080, 0);
    apb(0, 12'h040, 0);
    apb(1, 12'h07c, 32'hffffffff);      // R5 discarded write
    apb(0, 12'h03c, 0);
    apb(0, 12'h080, 0);
    apb(0, 12'h060, 0);                 // R5 zero read
    apb(0, 12'h0c0, 0);                 // R8 unmapped
    apb(1, 12'h088, 32'hfffffffe);      // R8 stim takes bit 0 only
    apb(0, 12'h088, 0);
    apb(1, 12'h088, 32'h1);
    apb(1, 12'h080, 32'hffffffff);      // R6 R7 R8 all fields + reserved
    apb(0, 12'h080, 0);
    apb(0, 12'h088, 0);
    apb(1, 12'h088, 32'h0);             // R7 stimulus drives prim_in
    apb(1, 12'h088, 32'h1);
    apb(1, 12'h080, 32'h10);            // R7 with normal clocking
    apb(0, 12'h050, 0);
    apb(1, 12'h080, 32'h0);             // R7 back to pin
    repeat (4) @(posedge clk);
    @(negedge clk);
    summary();
  end
endmodule